// File: doc/BRIEF.md
# Windowed Lookup-Table Address Translator

This block sits on one side of a bus bridge and rewrites incoming 32-bit addresses into the address space on the far side. The top bit of the address says whether the access belongs to the translated window. The next six bits pick one of 64 table entries. The low 25 bits are a byte offset within a window of up to 32 MB, and they pass through untouched. The selected entry supplies the seven upper bits of the outgoing address.

Software-side logic loads the table through a configuration write port. Each write stores a seven-bit upper field and a valid flag for one entry. A separate strobe programs the one-bit window base. A lookup is presented as an address with a valid strobe. One clock later the block returns either the translated address or a miss flag. A miss happens when the address lies outside the window or when the selected entry is not valid.

The table storage has no reset and uses a synchronous read, so it can map onto block RAM. The valid flags are kept in resettable flip-flops.

Top module: `lut_xlat_top`

## Requirements
- R1: On a hit, the output address is the 7-bit upper field of the selected entry in bits 31..25, followed by input bits 24..0 unchanged in bits 24..0.
- R2: The table index is input address bits 30..25, so each of the 64 entries is reachable independently. Entry 0 and entry 63 are distinct.
- R3: When input bit 31 differs from the programmed window base, the result raises `out_miss` and `out_addr` is zero.
- R4: When the selected entry's valid flag is clear, the result raises `out_miss` and `out_addr` is zero.
- R5: `out_vld` rises exactly one cycle after a cycle with `req_vld` high. In a cycle after `req_vld` was low, `out_vld`, `out_miss` and `out_addr` are all zero.
- R6: If a configuration write and a lookup address the same entry in the same cycle, the lookup returns the entry's previous contents.
- R7: Synchronous active-high reset clears every entry's valid flag, sets the window base to 0 and drives all outputs to zero.
- R8: A configuration write with `cfg_valid` low invalidates the entry, and later lookups of that entry miss.
- R9: A window base write takes effect for lookups issued from the following cycle onward. A lookup issued in the same cycle as the base write uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Table entry write strobe |
| cfg_idx | input | 6 | Entry index for the write |
| cfg_upper | input | 7 | Upper address field to store |
| cfg_valid | input | 1 | Valid flag to store |
| base_en | input | 1 | Window base write strobe |
| base_val | input | 1 | New window base value |
| req_vld | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Address to translate |
| out_vld | output | 1 | Result valid, one cycle after the request |
| out_miss | output | 1 | Result is a miss (outside window or invalid entry) |
| out_addr | output | 32 | Translated address, zero on miss or idle |

## Verification
The bench builds the block with its default parameters: a 6-bit index, a 25-bit offset and 64 entries. This makes both table ends (entry 0 and entry 63) and full-width offsets of all ones and all zeros directly reachable. In the random phase, indices are drawn from a small pool. Writes, base changes and lookups then collide on the same entry and in the same cycle often, which exercises the old-value rule and the base-update timing. Both window base values are used, so hits and window misses occur in roughly equal numbers.

// File: rtl/lut_xlat_pkg.sv
package lut_xlat_pkg;
  parameter int unsigned XL_IDX_W = 6;
  parameter int unsigned XL_OFF_W = 25;

  function automatic int unsigned xl_addr_w(int unsigned idx_w, int unsigned off_w);
    return 1 + idx_w + off_w;
  endfunction
endpackage

// File: rtl/xlat_table.sv
module xlat_table #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned UP_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [UP_W-1:0]  wr_upper,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [UP_W-1:0]  rd_upper,
  output logic             rd_valid
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [UP_W-1:0]    mem [ENTRIES];
  logic [ENTRIES-1:0] vld_vec;

  // storage without reset, read-before-write: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_upper;
    rd_upper <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_vec  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) vld_vec[wr_idx] <= wr_valid;
      rd_valid <= vld_vec[rd_idx];
    end
  end

  // R8: an invalidating write clears the entry's flag
  a_r8_invalidate: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_valid) |=> !vld_vec[$past(wr_idx)]);

  // R6: read sees the value present before a same-cycle write
  a_r6_old_value: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == rd_idx) && !$past(rst)) |=> (rd_valid == $past(vld_vec[rd_idx])));
endmodule

// File: rtl/xlat_window.sv
module xlat_window (
  input  logic clk,
  input  logic rst,
  input  logic base_en,
  input  logic base_val,
  input  logic top_bit,
  output logic in_win,
  output logic base_q
);
  always_ff @(posedge clk) begin
    if (rst)          base_q <= 1'b0;
    else if (base_en) base_q <= base_val;
  end

  assign in_win = (top_bit == base_q);

  // R9: base register follows a write on the next cycle
  a_r9_base_update: assert property (@(posedge clk) disable iff (rst)
    base_en |=> (base_q == $past(base_val)));
endmodule

// File: rtl/xlat_assemble.sv
module xlat_assemble #(
  parameter int unsigned OFF_W = 25,
  parameter int unsigned UP_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_vld,
  input  logic                  in_win,
  input  logic [OFF_W-1:0]      offset,
  input  logic [UP_W-1:0]       ent_upper,
  input  logic                  ent_valid,
  output logic                  out_vld,
  output logic                  out_miss,
  output logic [UP_W+OFF_W-1:0] out_addr
);
  logic             vld_q;
  logic             win_q;
  logic [OFF_W-1:0] off_q;
  logic             hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      win_q <= 1'b0;
      off_q <= '0;
    end else begin
      vld_q <= req_vld;
      win_q <= in_win;
      off_q <= offset;
    end
  end

  assign hit      = vld_q && win_q && ent_valid;
  assign out_vld  = vld_q;
  assign out_miss = vld_q && !hit;
  assign out_addr = hit ? {ent_upper, off_q} : '0;

  // R5: quiet outputs when no result is presented
  a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (!out_miss && (out_addr == '0)));

  // R3 / R4: a miss never carries an address
  a_r4_zero_on_miss: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> (out_addr == '0));
endmodule

// File: rtl/lut_xlat_top.sv
module lut_xlat_top
  import lut_xlat_pkg::*;
#(
  parameter int unsigned IDX_W = XL_IDX_W,
  parameter int unsigned OFF_W = XL_OFF_W,
  localparam int unsigned ADDR_W = xl_addr_w(IDX_W, OFF_W),
  localparam int unsigned UP_W   = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [UP_W-1:0]   cfg_upper,
  input  logic              cfg_valid,
  input  logic              base_en,
  input  logic              base_val,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_vld,
  output logic              out_miss,
  output logic [ADDR_W-1:0] out_addr
);
  logic [IDX_W-1:0] lk_idx;
  logic [UP_W-1:0]  ent_upper;
  logic             ent_valid;
  logic             in_win;
  logic             base_q;

  assign lk_idx = req_addr[OFF_W +: IDX_W];

  xlat_table #(.IDX_W(IDX_W), .UP_W(UP_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(cfg_en), .wr_idx(cfg_idx), .wr_upper(cfg_upper), .wr_valid(cfg_valid),
    .rd_idx(lk_idx), .rd_upper(ent_upper), .rd_valid(ent_valid)
  );

  xlat_window u_window (
    .clk(clk), .rst(rst),
    .base_en(base_en), .base_val(base_val),
    .top_bit(req_addr[ADDR_W-1]),
    .in_win(in_win), .base_q(base_q)
  );

  xlat_assemble #(.OFF_W(OFF_W), .UP_W(UP_W)) u_asm (
    .clk(clk), .rst(rst),
    .req_vld(req_vld), .in_win(in_win), .offset(req_addr[OFF_W-1:0]),
    .ent_upper(ent_upper), .ent_valid(ent_valid),
    .out_vld(out_vld), .out_miss(out_miss), .out_addr(out_addr)
  );

  // R5: a request yields a result on the next cycle
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> out_vld);

  // R3: out-of-window request misses
  a_r3_window_miss: assert property (@(posedge clk) disable iff (rst)
    (req_vld && (req_addr[ADDR_W-1] != base_q)) |=> out_miss);

  // R1: offset passes through on a hit
  a_r1_offset: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> (out_miss || (out_addr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]))));
endmodule

// File: tb/test_lut_xlat_top.sv
`timescale 1ns/1ps
module test_lut_xlat_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_en, cfg_valid, base_en, base_val, req_vld;
  logic [5:0]  cfg_idx;
  logic [6:0]  cfg_upper;
  logic [31:0] req_addr;
  logic        out_vld, out_miss;
  logic [31:0] out_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [6:0]  m_upper [64];
  logic [63:0] m_valid;
  logic        m_base;

  always #10 clk = ~clk;

  lut_xlat_top i_lut_xlat_top (
    .clk(clk), .rst(rst),
    .cfg_en(cfg_en), .cfg_idx(cfg_idx), .cfg_upper(cfg_upper), .cfg_valid(cfg_valid),
    .base_en(base_en), .base_val(base_val),
    .req_vld(req_vld), .req_addr(req_addr),
    .out_vld(out_vld), .out_miss(out_miss), .out_addr(out_addr)
  );

  function automatic logic [33:0] expect_res(logic rv, logic [31:0] a);
    logic [5:0] ix;
    ix = a[30:25];
    if (!rv) return 34'd0;
    if (a[31] != m_base || !m_valid[ix]) return {1'b1, 1'b1, 32'd0};
    return {1'b1, 1'b0, m_upper[ix], a[24:0]};
  endfunction

  task automatic check(string tag, logic [33:0] got, logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got vld=%0b miss=%0b addr=%h, expected vld=%0b miss=%0b addr=%h",
               tag, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  // one cycle: drive at negedge, result checked at the following negedge
  task automatic step(string tag, logic ce, logic [5:0] ci, logic [6:0] cu, logic cv,
                      logic be, logic bv, logic rv, logic [31:0] a);
    logic [33:0] exp;
    exp = expect_res(rv, a);
    cfg_en = ce; cfg_idx = ci; cfg_upper = cu; cfg_valid = cv;
    base_en = be; base_val = bv; req_vld = rv; req_addr = a;
    @(negedge clk);
    check(tag, {out_vld, out_miss, out_addr}, exp);
    if (ce) begin m_upper[ci] = cu; m_valid[ci] = cv; end
    if (be) m_base = bv;
  endtask

  task automatic wr(logic [5:0] ci, logic [6:0] cu, logic cv);
    step("R5", 1'b1, ci, cu, cv, 1'b0, 1'b0, 1'b0, 32'd0);
  endtask

  task automatic look(string tag, logic [31:0] a);
    step(tag, 1'b0, 6'd0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b1, a);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m_upper[i] = 7'd0;
    m_valid = '0; m_base = 1'b0;
    rst = 1'b1; cfg_en = 0; cfg_idx = 0; cfg_upper = 0; cfg_valid = 0;
    base_en = 0; base_val = 0; req_vld = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    check("R7", {out_vld, out_miss, out_addr}, 34'd0);
    rst = 1'b0;
    @(negedge clk);
    // R7: every entry invalid after reset
    look("R7", {1'b0, 6'd0, 25'h0});
    look("R7", {1'b0, 6'd63, 25'h1ABCDEF});
    // R2: both ends of the table
    wr(6'd0, 7'h15, 1'b1);
    wr(6'd63, 7'h6A, 1'b1);
    look("R2", {1'b0, 6'd0, 25'h1FFFFFF});
    look("R2", {1'b0, 6'd63, 25'h0});
    // R1: offset pass-through with mixed pattern
    look("R1", {1'b0, 6'd63, 25'h0A5A5A5});
    // R5: idle cycle after a request
    step("R5", 1'b0, 6'd0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF);
    // R3: top bit mismatch
    look("R3", {1'b1, 6'd0, 25'h123});
    // R9: base write with same-cycle lookup uses old base, then new base
    step("R9", 1'b0, 6'd0, 7'd0, 1'b0, 1'b1, 1'b1, 1'b1, {1'b1, 6'd63, 25'h77});
    look("R9", {1'b1, 6'd63, 25'h77});
    look("R3", {1'b0, 6'd63, 25'h77});
    // R6: same-cycle write and lookup on one entry
    step("R6", 1'b1, 6'd63, 7'h01, 1'b1, 1'b0, 1'b0, 1'b1, {1'b1, 6'd63, 25'h5});
    look("R6", {1'b1, 6'd63, 25'h5});
    // R8 / R4: invalidate then look up
    wr(6'd63, 7'h7F, 1'b0);
    look("R8", {1'b1, 6'd63, 25'h5});
    look("R4", {1'b1, 6'd17, 25'h5});
    // random phase
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 400; n++) begin
      logic [5:0]  ci;
      logic [31:0] a;
      logic [33:0] e;
      string       tag;
      ci = 6'($urandom % 4) + 6'd30;
      a  = $urandom;
      a[30:25] = 6'($urandom % 4) + 6'd30;
      e = expect_res(1'b1, a);
      if (a[31] != m_base) tag = "R3";
      else if (e[32]) tag = "R4";
      else tag = "R1";
      step(tag, ($urandom % 3) == 0, ci, 7'($urandom), ($urandom % 4) != 0,
           ($urandom % 8) == 0, 1'($urandom), ($urandom % 5) != 0, a);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule